// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one channel of an interval timer. A host programs it through an 8-bit byte port. First the host writes a 6-bit control word that selects the count format, the output mode and the byte access order. Then it writes a 16-bit start count as one or two bytes. The channel counts down on a one-cycle tick input (`cnt_tick`) while the `gate` input is high, and it shapes `tmr_out` to suit the selected mode. Three modes exist: a terminal-count output, a rate generator that gives a one-tick low pulse per period, and a square wave.

The host can read the count at any time. For a stable value it first strobes `latch_cnt`, which freezes a snapshot that is held until every byte of it has been read. A separate `latch_sts` strobe freezes a status byte. That byte holds the output level, a null-count flag that shows whether a freshly written count has reached the counter, and the programmed control bits. Address decoding and command parsing are not part of the block: the host side presents dedicated strobes. Everything runs on the single `clk` domain.

Top module: `tmr_channel`

## Requirements
- R1: After reset `tmr_out` is low and the control word is all zero (terminal-count mode, binary, access code 00). The count is zero, no latch is held, and a read returns 0x00.
- R2: A control write (`ctl_word`: bit 0 = BCD, bits 3..1 = mode code, bits 5..4 = access code) selects the mode. Codes 2 and 6 give the rate mode, 3 and 7 the square mode, and 0, 1, 4, 5 the terminal-count mode. Access code 00 behaves as 11. The write drives `tmr_out` low for terminal count and high otherwise, halts counting, resets both byte pointers and drops any held latch. It leaves the count value unchanged.
- R3: Access code 01 moves only the low byte (a write loads the high byte as zero). Code 10 moves only the high byte (a write loads the low byte as zero). Code 11 moves the low byte first, then the high byte, and a paired write only completes on its second byte.
- R4: A completed count write sets the null flag. The new value enters the counter on the next tick that follows it, with no decrement on that tick, and that load clears the null flag.
- R5: Once loaded, the counter changes only on a tick with `gate` high. A tick with `gate` low changes neither the count nor `tmr_out`.
- R6: With bit 0 set, the count steps in four BCD digits, each borrowing from 0 to 9 (1000 to 0999, 0000 to 9999). In binary, 0000 steps to FFFF. A start count of 0 therefore lasts 10000 or 65536 ticks.
- R7: Terminal-count mode: `tmr_out` is low after the control write and after each completed count write. It goes high on the tick that brings the count to zero, and it stays high while the counter keeps wrapping.
- R8: Rate mode: `tmr_out` is low for exactly the tick interval in which the count is 1. The next tick reloads the programmed value and raises `tmr_out`, so the period is N ticks.
- R9: Square mode: after the load `tmr_out` is high for ceil(N/2) ticks and then low for floor(N/2) ticks, repeating. In every mode `tmr_out` changes only on a tick or a host write.
- R10: `latch_cnt` copies the count. Reads return that copy while the counter runs on. Further `latch_cnt` strobes are ignored until the copy has been fully read: one byte for codes 01/10, two bytes for 11.
- R11: `latch_sts` freezes a status byte: bit 7 = `tmr_out`, bit 6 = null flag, bits 5..0 = control word. A second `latch_sts` is ignored while one is held. A held status is read before a held count, and one read releases it.
- R12: With no latch held, a read returns a byte of the live count, selected by the access code and the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 6 | Control word: access, mode, BCD |
| data_wr | input | 1 | Count byte write strobe |
| wr_byte | input | 8 | Count byte written by host |
| data_rd | input | 1 | Read strobe; advances the read sequence |
| rd_byte | output | 8 | Byte presented to the host this cycle |
| latch_cnt | input | 1 | Freeze the count for reading |
| latch_sts | input | 1 | Freeze the status byte for reading |
| cnt_tick | input | 1 | One-cycle counting tick |
| gate | input | 1 | Counting enable level |
| tmr_out | output | 1 | Timer output |

## Verification
The bench goes after the load tick: a design that decremented while loading would show a latched value one below the value written, and one that loaded on the same cycle as the write would report null as already cleared. It drives BCD borrows across several digits and the zero start count. A binary-only step would read back 0FFF or FFFF where 0999 and 9999 are due. It checks that a second latch strobe is ignored while a snapshot is half read: a design that re-latched would return mismatched byte halves. It also times the odd square-wave period tick by tick: an even split, or one with the long half low, shows up as a misplaced edge. The rate mode pulse is timed in the same way, so a pulse one tick early or too wide is caught.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CTL_W  = 6;
    localparam int NDIG   = CNT_W / 4;

    typedef enum logic [1:0] {
        MD_TERM   = 2'd0,
        MD_RATE   = 2'd1,
        MD_SQUARE = 2'd2
    } mode_e;

    localparam logic [1:0] ACC_LO = 2'b01;
    localparam logic [1:0] ACC_HI = 2'b10;

    // low two bits of the mode code decide: x10 rate, x11 square, rest terminal
    function automatic mode_e mode_decode(logic [1:0] code_lo);
        case (code_lo)
            2'b10:   return MD_RATE;
            2'b11:   return MD_SQUARE;
            default: return MD_TERM;
        endcase
    endfunction
endpackage

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        acc,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val
);
    typedef struct packed {
        logic              hi_next;
        logic [BYTE_W-1:0] lo_hold;
        logic [CNT_W-1:0]  val;
    } wseq_t;

    wseq_t ws_d, ws_q;

    always_comb begin
        ws_d     = ws_q;
        load_req = 1'b0;
        if (ctl_wr) begin
            ws_d.hi_next = 1'b0;
        end else if (data_wr) begin
            if (acc == ACC_LO) begin
                ws_d.val = {{BYTE_W{1'b0}}, wr_byte};
                load_req = 1'b1;
            end else if (acc == ACC_HI) begin
                ws_d.val = {wr_byte, {BYTE_W{1'b0}}};
                load_req = 1'b1;
            end else if (!ws_q.hi_next) begin
                ws_d.lo_hold = wr_byte;
                ws_d.hi_next = 1'b1;
            end else begin
                ws_d.val     = {wr_byte, ws_q.lo_hold};
                ws_d.hi_next = 1'b0;
                load_req     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ws_q <= '0;
        else        ws_q <= ws_d;
    end

    assign load_val = ws_q.val;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  mode_e            wr_mode,
    input  mode_e            mode,
    input  logic             bcd,
    input  logic             cnt_tick,
    input  logic             gate,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             out_lvl,
    output logic             null_cnt,
    output logic             armed,
    output logic             pend
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             nul;
        logic             armed;
        logic             pend;
    } core_t;

    core_t cs_d, cs_q;
    logic [CNT_W-1:0] step1, step2;

    function automatic logic [CNT_W-1:0] dec_one(logic [CNT_W-1:0] v, logic use_bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        if (!use_bcd) return v - ONE;
        r      = v;
        borrow = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (borrow) begin
                if (v[4*i +: 4] == 4'd0) begin
                    r[4*i +: 4] = 4'd9;
                end else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

    always_comb begin
        cs_d  = cs_q;
        step1 = dec_one(cs_q.cnt, bcd);
        step2 = dec_one(step1, bcd);
        if (ctl_wr) begin
            cs_d.out   = (wr_mode != MD_TERM);
            cs_d.pend  = 1'b0;
            cs_d.armed = 1'b0;
            cs_d.nul   = 1'b1;
        end else begin
            if (load_req) begin
                cs_d.pend = 1'b1;
                cs_d.nul  = 1'b1;
                if (mode == MD_TERM) cs_d.out = 1'b0;
            end
            if (cnt_tick) begin
                if (cs_q.pend && !load_req) begin
                    cs_d.cnt   = load_val;
                    cs_d.armed = 1'b1;
                    cs_d.pend  = 1'b0;
                    cs_d.nul   = 1'b0;
                    if (mode != MD_TERM) cs_d.out = 1'b1;
                end else if (cs_q.armed && gate) begin
                    case (mode)
                        MD_RATE: begin
                            if (cs_q.cnt == ONE) begin
                                cs_d.cnt = load_val;
                                cs_d.out = 1'b1;
                            end else begin
                                cs_d.cnt = step1;
                                cs_d.out = (step1 != ONE);
                            end
                        end
                        MD_SQUARE: begin
                            if (cs_q.cnt == ONE || cs_q.cnt == TWO) begin
                                cs_d.out = !cs_q.out;
                                // low half takes the even part of N
                                cs_d.cnt = cs_q.out ? {load_val[CNT_W-1:1], 1'b0} : load_val;
                            end else begin
                                cs_d.cnt = step2;
                            end
                        end
                        default: begin
                            cs_d.cnt = step1;
                            if (step1 == '0) cs_d.out = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count    = cs_q.cnt;
    assign out_lvl  = cs_q.out;
    assign null_cnt = cs_q.nul;
    assign armed    = cs_q.armed;
    assign pend     = cs_q.pend;
endmodule

// File: rtl/tmr_rd_latch.sv
module tmr_rd_latch
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [1:0]        acc,
    input  logic              latch_cnt,
    input  logic              latch_sts,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [BYTE_W-1:0] live_sts,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cnt_held,
    output logic              sts_held,
    output logic [CNT_W-1:0]  cnt_snap,
    output logic [BYTE_W-1:0] sts_snap
);
    typedef struct packed {
        logic [CNT_W-1:0]  snap;
        logic              cheld;
        logic [BYTE_W-1:0] sts;
        logic              sheld;
        logic              rptr;
    } rlat_t;

    rlat_t rl_d, rl_q;
    logic [CNT_W-1:0] src_word;
    logic             pair, hi_sel;

    always_comb begin
        pair     = (acc != ACC_LO) && (acc != ACC_HI);
        hi_sel   = (acc == ACC_HI) || (pair && rl_q.rptr);
        src_word = rl_q.cheld ? rl_q.snap : live_cnt;
        if (rl_q.sheld)  rd_byte = rl_q.sts;
        else if (hi_sel) rd_byte = src_word[CNT_W-1 -: BYTE_W];
        else             rd_byte = src_word[BYTE_W-1:0];

        rl_d = rl_q;
        if (ctl_wr) begin
            rl_d.cheld = 1'b0;
            rl_d.sheld = 1'b0;
            rl_d.rptr  = 1'b0;
        end else begin
            if (data_rd) begin
                if (rl_q.sheld) begin
                    rl_d.sheld = 1'b0;
                end else if (pair) begin
                    rl_d.rptr = !rl_q.rptr;
                    if (rl_q.rptr) rl_d.cheld = 1'b0;
                end else begin
                    rl_d.cheld = 1'b0;
                end
            end
            if (latch_cnt && !rl_q.cheld) begin
                rl_d.snap  = live_cnt;
                rl_d.cheld = 1'b1;
            end
            if (latch_sts && !rl_q.sheld) begin
                rl_d.sts   = live_sts;
                rl_d.sheld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rl_q <= '0;
        else        rl_q <= rl_d;
    end

    assign cnt_held = rl_q.cheld;
    assign sts_held = rl_q.sheld;
    assign cnt_snap = rl_q.snap;
    assign sts_snap = rl_q.sts;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              latch_cnt,
    input  logic              latch_sts,
    input  logic              cnt_tick,
    input  logic              gate,
    output logic              tmr_out
);
    logic [CTL_W-1:0]  ctl_d, ctl_q;
    mode_e             run_mode, wr_mode;
    logic              load_req, null_cnt, armed, pend;
    logic              cnt_held, sts_held;
    logic [CNT_W-1:0]  load_val, cnt_live, cnt_snap;
    logic [BYTE_W-1:0] live_sts, sts_snap;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = ctl_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign run_mode = mode_decode(ctl_q[2:1]);
    assign wr_mode  = mode_decode(ctl_word[2:1]);
    assign live_sts = {tmr_out, null_cnt, ctl_q};

    tmr_wr_seq u_wseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .acc      (ctl_q[5:4]),
        .data_wr  (data_wr),
        .wr_byte  (wr_byte),
        .load_req (load_req),
        .load_val (load_val)
    );

    tmr_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wr_mode  (wr_mode),
        .mode     (run_mode),
        .bcd      (ctl_q[0]),
        .cnt_tick (cnt_tick),
        .gate     (gate),
        .load_req (load_req),
        .load_val (load_val),
        .count    (cnt_live),
        .out_lvl  (tmr_out),
        .null_cnt (null_cnt),
        .armed    (armed),
        .pend     (pend)
    );

    tmr_rd_latch u_rlat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .acc       (ctl_q[5:4]),
        .latch_cnt (latch_cnt),
        .latch_sts (latch_sts),
        .data_rd   (data_rd),
        .live_cnt  (cnt_live),
        .live_sts  (live_sts),
        .rd_byte   (rd_byte),
        .cnt_held  (cnt_held),
        .sts_held  (sts_held),
        .cnt_snap  (cnt_snap),
        .sts_snap  (sts_snap)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              data_wr,
    input logic              data_rd,
    input logic              cnt_tick,
    input logic              tmr_out,
    input logic [1:0]        run_mode,
    input logic [CNT_W-1:0]  cnt_live,
    input logic              armed,
    input logic              pend,
    input logic              null_cnt,
    input logic              cnt_held,
    input logic [CNT_W-1:0]  cnt_snap,
    input logic              sts_held,
    input logic [BYTE_W-1:0] sts_snap
);
    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(cnt_live));

    // R7
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'd0 && tmr_out && !ctl_wr && !data_wr) |=> tmr_out);

    // R8
    rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == 2'd1 && armed && !tmr_out) |-> (cnt_live == CNT_W'(1)));

    // R9
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !ctl_wr && !data_wr) |=> $stable(tmr_out));

    // R4
    null_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && cnt_tick && !data_wr && !ctl_wr) |=> !null_cnt);

    // R10
    cnt_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_held && !data_rd && !ctl_wr) |=> (cnt_held && $stable(cnt_snap)));

    // R11
    sts_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_held && !data_rd && !ctl_wr) |=> (sts_held && $stable(sts_snap)));
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .cnt_tick (cnt_tick),
    .tmr_out  (tmr_out),
    .run_mode (run_mode),
    .cnt_live (cnt_live),
    .armed    (armed),
    .pend     (pend),
    .null_cnt (null_cnt),
    .cnt_held (cnt_held),
    .cnt_snap (cnt_snap),
    .sts_held (sts_held),
    .sts_snap (sts_snap)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_word = '0;
    logic       data_wr = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       data_rd = 1'b0;
    logic [7:0] rd_byte;
    logic       latch_cnt = 1'b0;
    logic       latch_sts = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       gate = 1'b1;
    logic       tmr_out;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_val_q[$];
    string      exp_req_q[$];
    logic [7:0] mon_v;
    string      mon_r;

    always #10 clk = !clk;

    tmr_channel u_tmr_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_word  (ctl_word),
        .data_wr   (data_wr),
        .wr_byte   (wr_byte),
        .data_rd   (data_rd),
        .rd_byte   (rd_byte),
        .latch_cnt (latch_cnt),
        .latch_sts (latch_sts),
        .cnt_tick  (cnt_tick),
        .gate      (gate),
        .tmr_out   (tmr_out)
    );

    // monitor: compares every host read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && data_rd) begin
            checks++;
            if (exp_val_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected read actual %02h expected none", rd_byte);
            end else begin
                mon_v = exp_val_q.pop_front();
                mon_r = exp_req_q.pop_front();
                if (rd_byte !== mon_v) begin
                    errors++;
                    $display("FAIL %s read actual %02h expected %02h", mon_r, rd_byte, mon_v);
                end
            end
        end
    end

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [5:0] w);
        ctl_word = w; ctl_wr = 1'b1; nxt(); ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] b);
        wr_byte = b; data_wr = 1'b1; nxt(); data_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        exp_val_q.push_back(exp);
        exp_req_q.push_back(req);
        data_rd = 1'b1; nxt(); data_rd = 1'b0;
    endtask

    task automatic lat_c();
        latch_cnt = 1'b1; nxt(); latch_cnt = 1'b0;
    endtask

    task automatic lat_s();
        latch_sts = 1'b1; nxt(); latch_sts = 1'b0;
    endtask

    task automatic tick(input logic g);
        gate = g; cnt_tick = 1'b1; nxt(); cnt_tick = 1'b0;
    endtask

    task automatic chk_out(input logic exp, input string req);
        checks++;
        if (tmr_out !== exp) begin
            errors++;
            $display("FAIL %s out actual %b expected %b", req, tmr_out, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] sq_odd;
        logic [3:0] sq_even;
        logic [5:0] rate_seq;
        sq_odd   = 9'b001110011;  // LSB first: 1,1,0,0,1,1,1,0,0
        sq_even  = 4'b1001;       // LSB first: 1,0,0,1
        rate_seq = 6'b101101;     // LSB first: 1,0,1,1,0,1

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_out(1'b0, "R1");
        rd(8'h00, "R1");

        // terminal count, binary, pair access
        wr_ctl(6'h30);
        chk_out(1'b0, "R2");
        wr_cnt(8'h05); wr_cnt(8'h00);
        lat_s(); rd(8'h70, "R4");
        tick(1'b1);                       // load tick
        lat_c(); rd(8'h05, "R4"); rd(8'h00, "R4");
        lat_s(); rd(8'h30, "R4");
        tick(1'b0); tick(1'b0); tick(1'b0);
        chk_out(1'b0, "R5");
        lat_c(); rd(8'h05, "R5"); rd(8'h00, "R5");
        for (int i = 0; i < 4; i++) tick(1'b1);
        chk_out(1'b0, "R7");
        tick(1'b1);
        chk_out(1'b1, "R7");
        lat_s(); rd(8'hB0, "R11");
        tick(1'b1);
        chk_out(1'b1, "R7");
        lat_c(); rd(8'hFF, "R6"); rd(8'hFF, "R6");

        // R10 frozen snapshot, second latch ignored
        lat_c();
        tick(1'b1); tick(1'b1);
        lat_c();
        rd(8'hFF, "R10");
        tick(1'b1);
        rd(8'hFF, "R10");
        lat_c(); rd(8'hFC, "R10"); rd(8'hFF, "R10");
        wr_cnt(8'h02); wr_cnt(8'h00);
        chk_out(1'b0, "R7");

        // R6 BCD
        wr_ctl(6'h31);
        wr_cnt(8'h00); wr_cnt(8'h10);
        tick(1'b1); tick(1'b1);
        lat_c(); rd(8'h99, "R6"); rd(8'h09, "R6");
        wr_cnt(8'h00); wr_cnt(8'h00);
        tick(1'b1); tick(1'b1);
        lat_c(); rd(8'h99, "R6"); rd(8'h99, "R6");

        // R3 single-byte access codes
        wr_ctl(6'h10);
        wr_cnt(8'h34);
        tick(1'b1);
        lat_c(); rd(8'h34, "R3");
        wr_ctl(6'h20);
        wr_cnt(8'h12);
        tick(1'b1);
        lat_c(); rd(8'h12, "R3");
        wr_ctl(6'h30);
        rd(8'h00, "R12"); rd(8'h12, "R12");

        // R2 access code 00 acts as pair
        wr_ctl(6'h00);
        wr_cnt(8'h21); wr_cnt(8'h43);
        tick(1'b1);
        lat_c(); rd(8'h21, "R2"); rd(8'h43, "R2");

        // R8 rate mode
        wr_ctl(6'h34);
        chk_out(1'b1, "R2");
        wr_cnt(8'h03); wr_cnt(8'h00);
        tick(1'b1);
        chk_out(1'b1, "R8");
        for (int i = 0; i < 6; i++) begin
            tick(1'b1);
            chk_out(rate_seq[i], "R8");
        end
        wr_cnt(8'h04); wr_cnt(8'h00);
        lat_s(); rd(8'hF4, "R4");
        tick(1'b1);
        lat_c(); lat_s();
        rd(8'hB4, "R11"); rd(8'h04, "R10"); rd(8'h00, "R10");
        lat_s();
        tick(1'b1); tick(1'b1); tick(1'b1);
        chk_out(1'b0, "R8");
        lat_s();
        rd(8'hB4, "R11");
        lat_s(); rd(8'h34, "R11");

        // R2 mode code aliases
        wr_ctl(6'h3C); chk_out(1'b1, "R2");
        wr_ctl(6'h32); chk_out(1'b0, "R2");
        wr_ctl(6'h3E); chk_out(1'b1, "R2");
        wr_ctl(6'h38); chk_out(1'b0, "R2");

        // R9 square wave, odd then even
        wr_ctl(6'h36);
        wr_cnt(8'h05); wr_cnt(8'h00);
        tick(1'b1);
        chk_out(1'b1, "R9");
        for (int i = 0; i < 9; i++) begin
            tick(1'b1);
            chk_out(sq_odd[i], "R9");
        end
        wr_cnt(8'h04); wr_cnt(8'h00);
        tick(1'b1);
        chk_out(1'b1, "R9");
        for (int i = 0; i < 4; i++) begin
            tick(1'b1);
            chk_out(sq_even[i], "R9");
        end

        nxt();
        checks++;
        if (exp_val_q.size() != 0) begin
            errors++;
            $display("FAIL R12 pending reads actual %0d expected 0", exp_val_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule